// File: doc/BRIEF.md
# Broadcast-Input Systolic FIR Filter

This block is a linear systolic array that filters a stream of signed samples with a three-tap FIR response, y(n) = w0·x(n) + w1·x(n-1) + w2·x(n-2). Each tap has its own processing element, and each element keeps its coefficient in a local register. Every accepted sample goes to all elements in the same clock. The partial sum moves one element per clock through a single register per hop. It starts as zero at the element that holds w2 and finishes at the element that holds w0, which drives the result port.

A new sample can be accepted on every clock, so every element does one multiply-accumulate per accepted sample. Coefficients are written one tap at a time through a write-enable and tap-index port while the sample stream is idle. A clock with no valid sample freezes the whole array.

Top module: `fir_bcast_array`

## Requirements
- R1: While reset is asserted and on its release, `out_valid_o` is 0 and `out_data_o` is 0.
- R2: When a sample is presented with `in_valid_i` high on a clock edge, `out_data_o` equals w0·x(n) + w1·x(n-1) + w2·x(n-2) from the following cycle. Here x(n) is that sample, and x(n-1) and x(n-2) are the two previously accepted samples.
- R3: `out_valid_o` is high for exactly the cycle after an accepted sample, and only once at least three samples have been accepted since reset. It stays low after the first and second samples.
- R4: A cycle with `in_valid_i` low leaves `out_data_o` unchanged and gives `out_valid_o` low in the following cycle. Skipped cycles do not count as samples.
- R5: With `in_valid_i` low, a write with `coef_we_i` high stores `coef_data_i` as coefficient w_k, where k is the value on `coef_idx_i` (0 addresses the tap applied to the newest sample).
- R6: A coefficient write presented while `in_valid_i` is high is ignored, and all three coefficients keep their values.
- R7: A coefficient write to an index of 3 or more is ignored.
- R8: Samples and coefficients are signed 16-bit two's complement values. The 34-bit signed result never wraps, including when all samples and coefficients are -32768, which gives 3221225472.
- R9: Before three samples have entered, `out_data_o` shows the convolution with zeros in place of samples before reset: w0·x(0), then w1·x(0) + w0·x(1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid_i | input | 1 | Sample present on this clock |
| in_data_i | input | 16 | Signed input sample |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_idx_i | input | 2 | Tap index of the coefficient to write |
| coef_data_i | input | 16 | Signed coefficient value |
| out_valid_o | output | 1 | Result is a complete three-tap output |
| out_data_o | output | 34 | Signed filter result |

## Verification
The bench uses the default build: three taps and 16-bit samples and coefficients. A grid of five values covers both extremes, minus one, zero and plus one. Every one of the 125 coefficient triples on that grid runs against a sample sequence drawn from the same grid, with a stall inserted. This exercises every sign combination and the largest product sums. Random trials then add writes that must be ignored, both during streaming and to the unused index, and a separate run checks the all-minimum case for overflow.

// File: rtl/fir_bcast_pkg.sv
package fir_bcast_pkg;

  // Accumulator width: one full product plus growth for summing all taps.
  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + ((taps > 1) ? $clog2(taps) : 0);
  endfunction

  // Width of an index that addresses one tap.
  function automatic int idx_width(input int taps);
    return (taps > 1) ? $clog2(taps) : 1;
  endfunction

endpackage

// File: rtl/fir_pe.sv
module fir_pe #(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int AW = 34
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] w_i,
  input  logic signed [AW-1:0] sum_i,
  output logic signed [AW-1:0] sum_o
);
  localparam int PW = DW + CW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] sum_d;
  logic signed [AW-1:0] sum_q;

  always_comb begin
    prod     = x_i * w_i;
    prod_ext = AW'(prod);
    sum_d    = sum_i + prod_ext;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sum_q <= '0;
    else if (en_i) sum_q <= sum_d;
  end

  assign sum_o = sum_q;
endmodule

// File: rtl/fir_coef_bank.sv
module fir_coef_bank #(
  parameter int TAPS = 3,
  parameter int CW   = 16,
  parameter int IW   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     busy_i,
  input  logic                     we_i,
  input  logic [IW-1:0]            idx_i,
  input  logic [CW-1:0]            data_i,
  output logic [TAPS-1:0][CW-1:0]  w_o
);
  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic          load;
    logic [CW-1:0] w_q;

    always_comb load = we_i && !busy_i && (idx_i == IW'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   w_q <= '0;
      else if (load) w_q <= data_i;
    end

    assign w_o[k] = w_q;
  end
endmodule

// File: rtl/fir_fill_tracker.sv
module fir_fill_tracker #(
  parameter int TAPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  output logic out_valid_o
);
  localparam int CNTW = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam logic [CNTW-1:0] FULL = CNTW'(TAPS - 1);

  logic [CNTW-1:0] cnt_d, cnt_q;
  logic            vld_d, vld_q;

  always_comb begin
    cnt_d = cnt_q;
    vld_d = 1'b0;
    if (in_valid_i) begin
      vld_d = (cnt_q == FULL);
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      vld_q <= vld_d;
    end
  end

  assign out_valid_o = vld_q;
endmodule

// File: rtl/fir_bcast_array.sv
module fir_bcast_array
  import fir_bcast_pkg::*;
#(
  parameter  int TAPS = 3,
  parameter  int DW   = 16,
  parameter  int CW   = 16,
  localparam int IW   = idx_width(TAPS),
  localparam int AW   = acc_width(DW, CW, TAPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic [DW-1:0] in_data_i,
  input  logic          coef_we_i,
  input  logic [IW-1:0] coef_idx_i,
  input  logic [CW-1:0] coef_data_i,
  output logic          out_valid_o,
  output logic [AW-1:0] out_data_o
);
  logic [TAPS-1:0][CW-1:0] weights;
  logic [TAPS:0][AW-1:0]   psum;

  fir_coef_bank #(.TAPS(TAPS), .CW(CW), .IW(IW)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (in_valid_i),
    .we_i   (coef_we_i),
    .idx_i  (coef_idx_i),
    .data_i (coef_data_i),
    .w_o    (weights)
  );

  // Chain head: the element holding the oldest-sample tap starts from zero.
  assign psum[TAPS] = '0;

  for (genvar k = 0; k < TAPS; k++) begin : g_pe
    fir_pe #(.DW(DW), .CW(CW), .AW(AW)) u_pe (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (in_valid_i),
      .x_i    (in_data_i),
      .w_i    (weights[k]),
      .sum_i  (psum[k+1]),
      .sum_o  (psum[k])
    );
  end

  fir_fill_tracker #(.TAPS(TAPS)) u_fill (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .out_valid_o (out_valid_o)
  );

  assign out_data_o = psum[0];
endmodule

// File: rtl/fir_bcast_array_chk.sv
module fir_bcast_array_chk #(
  parameter int TAPS = 3,
  parameter int AW   = 34
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          in_valid_i,
  input logic          out_valid_o,
  input logic [AW-1:0] out_data_o
);
  localparam int SW = $clog2(TAPS + 1);

  logic [SW-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= '0;
    else if (in_valid_i && (seen_q != SW'(TAPS))) seen_q <= seen_q + 1'b1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!out_valid_o && (out_data_o == '0));
    end
  end

  // R3
  valid_needs_input_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));

  // R3
  valid_needs_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (seen_q >= SW'(TAPS)));

  // R3
  valid_after_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q >= SW'(TAPS)) && $past(in_valid_i)) |-> out_valid_o);

  // R4
  idle_holds_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> $stable(out_data_o));

  // R4
  idle_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
endmodule

bind fir_bcast_array fir_bcast_array_chk #(.TAPS(TAPS), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .out_valid_o (out_valid_o),
  .out_data_o  (out_data_o)
);

// File: tb/fir_bcast_array_bench.sv
module fir_bcast_array_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TAPS = 3;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        in_valid_i;
  logic [15:0] in_data_i;
  logic        coef_we_i;
  logic [1:0]  coef_idx_i;
  logic [15:0] coef_data_i;
  logic        out_valid_o;
  logic [33:0] out_data_o;

  int checks = 0;
  int errors = 0;

  longint w_m [TAPS];
  longint h_m [TAPS];
  longint exp_y;
  int     nsamp;

  int grid [5] = '{-32768, -1, 0, 1, 32767};

  fir_bcast_array u_fir_bcast_array (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_data_i   (in_data_i),
    .coef_we_i   (coef_we_i),
    .coef_idx_i  (coef_idx_i),
    .coef_data_i (coef_data_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk_val(string tag, longint act, longint expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    in_valid_i = 1'b0; in_data_i = '0;
    coef_we_i = 1'b0; coef_idx_i = '0; coef_data_i = '0;
    repeat (2) @(negedge clk_i);
    chk_val("R1", longint'(out_valid_o), 0, "valid in reset");
    chk_val("R1", longint'($signed(out_data_o)), 0, "data in reset");
    rst_ni = 1'b1;
    for (int k = 0; k < TAPS; k++) begin w_m[k] = 0; h_m[k] = 0; end
    exp_y = 0; nsamp = 0;
    @(negedge clk_i);
    chk_val("R1", longint'(out_valid_o), 0, "valid after release");
    chk_val("R1", longint'($signed(out_data_o)), 0, "data after release");
  endtask

  // One clock: drive at a falling edge, check at the next falling edge.
  task automatic step(bit v, int x, bit we, int idx, int d, string tag);
    string t;
    bit    exp_v;
    in_valid_i = v; in_data_i = 16'(x);
    coef_we_i = we; coef_idx_i = 2'(idx); coef_data_i = 16'(d);
    @(negedge clk_i);
    if (we && !v && idx < TAPS) w_m[idx] = longint'($signed(16'(d)));
    exp_v = 1'b0;
    if (v) begin
      for (int k = TAPS - 1; k > 0; k--) h_m[k] = h_m[k-1];
      h_m[0] = longint'($signed(16'(x)));
      nsamp++;
      exp_y = 0;
      for (int k = 0; k < TAPS; k++) exp_y += w_m[k] * h_m[k];
      exp_v = (nsamp >= TAPS);
    end
    if (tag != "") t = tag;
    else if (!v) t = "R4";
    else if (nsamp < TAPS) t = "R9";
    else t = "R2";
    chk_val(v ? "R3" : "R4", longint'(out_valid_o), longint'(exp_v), "valid");
    chk_val(t, longint'($signed(out_data_o)), exp_y, "data");
  endtask

  task automatic load(int c0, int c1, int c2);
    step(0, 0, 1, 0, c0, "R5");
    step(0, 0, 1, 1, c1, "R5");
    step(0, 0, 1, 2, c2, "R5");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung run expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();

    // R5: impulse per tap reveals each stored coefficient in order.
    load(7, -3, 11);
    step(1, 1, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");

    // Grid sweep over all coefficient triples (R2, R3, R4, R9).
    for (int a = 0; a < 5; a++)
      for (int b = 0; b < 5; b++)
        for (int c = 0; c < 5; c++) begin
          do_reset();
          load(grid[a], grid[b], grid[c]);
          for (int s = 0; s < 8; s++) begin
            if (s == 4) step(0, 0, 0, 0, 0, "");
            step(1, grid[(s * 3 + a + 2 * b + c) % 5], 0, 0, 0, "");
          end
        end

    // R8: largest magnitude sum.
    do_reset();
    load(-32768, -32768, -32768);
    for (int s = 0; s < 5; s++) step(1, -32768, 0, 0, 0, (s >= 2) ? "R8" : "");
    chk_val("R8", longint'($signed(out_data_o)), 64'sd3221225472, "max sum");

    // Random trials with ignored writes (R6, R7) and stalls (R4).
    for (int tr = 0; tr < 40; tr++) begin
      do_reset();
      load(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
           int'($signed(16'($urandom))));
      for (int s = 0; s < 20; s++) begin
        if (s == 8) begin
          step(1, int'($signed(16'($urandom))), 1, tr % 3, 12345, "R6");
          step(1, int'($signed(16'($urandom))), 0, 0, 0, "R6");
        end else if (s == 14) begin
          step(0, 0, 1, 3, 777, "R7");
          step(1, int'($signed(16'($urandom))), 0, 0, 0, "R7");
          step(1, int'($signed(16'($urandom))), 0, 0, 0, "R7");
        end else if (($urandom % 5) == 0) begin
          step(0, 0, 0, 0, 0, "");
        end else begin
          step(1, int'($signed(16'($urandom))), 0, 0, 0, "");
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule